// File: doc/BRIEF.md
# Debug trigger semaphore register

This block is a bank of sticky event flags. On-chip bus masters, such as a processor or a DMA engine, use it to tell an external calibration or debug tool which of up to 32 data items now hold fresh values. A bus master can raise any flag by writing a word with that bit at 1, but it can never lower one. A registered trigger pin stays high while at least one flag is raised, so the tool knows there is work waiting.

The tool reads the flags through a separate debug read port that cannot write. Each debug read returns the whole flag word and then clears every flag at once. Bus reads return the flags without changing them. Only full-word bus accesses are honoured. Any narrower or reserved-size access leaves the flags alone and returns a one-cycle error pulse.

The device reset raises all flags. The debug reset only quiets the debug read port and never touches the flags.

Top module: `dbg_sema_reg`

## Requirements
- R1: While `rst_n` is low, every flag is set to 1 and `trig_out` is 1. After release, `bus_err` and `dbg_rvalid` are 0 until some access causes them.
- R2: A bus write with `bus_sel`=1, `bus_wr`=1 and `bus_size`=2'b10 (full word) ORs `bus_wdata` into the flags. The result is visible to the next access.
- R3: A bit written as 0 by a bus write keeps its previous value. No bus access ever clears a flag.
- R4: A full-word bus read (`bus_sel`=1, `bus_wr`=0, `bus_size`=2'b10) presents the current flags on `bus_rdata` one cycle later and leaves the flags unchanged.
- R5: A bus access with `bus_size` of 2'b00 (byte), 2'b01 (half word) or 2'b11 (reserved) does not modify the flags. It drives `bus_err` high in the following cycle, for one cycle per such access. A valid access leaves `bus_err` low.
- R6: A debug read (`dbg_rd`=1 while `dbg_rst_n` is high) drives `dbg_rvalid` high for one cycle on the next cycle. At that point `dbg_rdata` holds the flags as they were before the read, and all flags are 0.
- R7: When a debug read and a valid bus write fall in the same cycle, the debug read returns the old flags. After that cycle the flags equal exactly the bits written as 1, so no newly raised event is lost.
- R8: While `dbg_rst_n` is low, the flags keep their value, `dbg_rd` is ignored and `dbg_rvalid` is 0 in the following cycle.
- R9: `trig_out` is a registered signal equal to the OR of all flags. It changes in the same cycle as the flags and drops once a debug read has cleared every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous; sets all flags |
| dbg_rst_n | input | 1 | Debug reset, active low, synchronous; resets the debug read port only |
| bus_sel | input | 1 | Bus access strobe for this register |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 00 byte, 01 half word, 10 word, 11 reserved |
| bus_wdata | input | 32 | Write data; 1 bits raise flags |
| bus_rdata | output | 32 | Flags captured by the last valid bus read |
| bus_err | output | 1 | One-cycle error response for an invalid-size access |
| dbg_rd | input | 1 | Debug read strobe; clears all flags |
| dbg_rdata | output | 32 | Flags returned by the last debug read |
| dbg_rvalid | output | 1 | One-cycle pulse marking `dbg_rdata` as fresh |
| trig_out | output | 1 | High while any flag is set |

## Verification
Two things can happen in the same clock cycle: a bus master raising flags through a full-word write, and the tool clearing everything with a debug read. The bench provokes the collision by asserting `dbg_rd` together with a word write in one cycle, and it also tries it while the debug reset is held low. The bench keeps its own model of the flags. It expects the debug read to return the word from before the write. A later bus read must show exactly the written bits. During a debug reset the write alone must be merged.

// File: rtl/dbg_sema_pkg.sv
package dbg_sema_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam int unsigned SIZE_W = 2;

  // only a full word access is honoured
  function automatic logic size_is_word(input logic [SIZE_W-1:0] sz);
    return acc_size_e'(sz) == SZ_WORD;
  endfunction

endpackage

// File: rtl/dbg_sema_bus_if.sv
module dbg_sema_bus_if
  import dbg_sema_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     flags_i,
  output logic              set_en_o,
  output logic [DW-1:0]     set_mask_o,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o
);

  logic size_ok;
  logic wr_hit;
  logic rd_hit;
  logic bad_acc;
  logic [DW-1:0] rdata_q;
  logic          err_q;

  assign size_ok    = size_is_word(size_i);
  assign wr_hit     = sel_i & wr_i & size_ok;
  assign rd_hit     = sel_i & ~wr_i & size_ok;
  assign bad_acc    = sel_i & ~size_ok;
  assign set_en_o   = wr_hit;
  assign set_mask_o = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= bad_acc;
      if (rd_hit) rdata_q <= flags_i;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R5
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && (size_i != SZ_WORD)) |=> err_o);

  // R5
  good_size_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i || (size_i == SZ_WORD)) |=> !err_o);

  // R4
  bus_rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_i && (size_i == SZ_WORD)) |=> (rdata_o == $past(flags_i)));

endmodule

// File: rtl/dbg_sema_flags.sv
module dbg_sema_flags #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en_i,
  input  logic [DW-1:0] set_mask_i,
  input  logic          clr_i,
  output logic [DW-1:0] flags_o,
  output logic [DW-1:0] flags_nxt_o
);

  logic [DW-1:0] flags_q;
  logic [DW-1:0] flags_nxt;

  // clear all first, then merge newly raised bits so none is lost
  function automatic logic [DW-1:0] next_flags(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] raise,
                                               input logic          wipe);
    logic [DW-1:0] kept;
    kept = wipe ? '0 : cur;
    return kept | raise;
  endfunction

  assign flags_nxt = next_flags(flags_q, set_en_i ? set_mask_i : '0, clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '1;
    else        flags_q <= flags_nxt;
  end

  assign flags_o     = flags_q;
  assign flags_nxt_o = flags_nxt;

  // R3
  no_bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en_i && !clr_i) |=> $stable(flags_q));

  // R7
  set_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_en_i) |=> (flags_q == $past(set_mask_i)));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_en_i) |=> (flags_q == '0));

endmodule

// File: rtl/dbg_sema_dbg_port.sv
module dbg_sema_dbg_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_rst_n,
  input  logic          rd_i,
  input  logic [DW-1:0] flags_i,
  output logic          clr_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  logic          rd_ok;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  assign rd_ok = rd_i & dbg_rst_n;
  assign clr_o = rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else if (!dbg_rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_ok;
      if (rd_ok) rdata_q <= flags_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R6
  dbg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n || !dbg_rst_n)
    rd_i |=> (rvalid_o && (rdata_o == $past(flags_i))));

  // R8
  dbg_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_rst_n |=> !rvalid_o);

endmodule

// File: rtl/dbg_sema_trig.sv
module dbg_sema_trig #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] flags_nxt_i,
  output logic          trig_o
);

  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b1;
    else        trig_q <= |flags_nxt_i;
  end

  assign trig_o = trig_q;

endmodule

// File: rtl/dbg_sema_reg.sv
module dbg_sema_reg
  import dbg_sema_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic              dbg_rd,
  output logic [DW-1:0]     dbg_rdata,
  output logic              dbg_rvalid,
  output logic              trig_out
);

  logic          set_en;
  logic [DW-1:0] set_mask;
  logic          dbg_clr;
  logic [DW-1:0] flags;
  logic [DW-1:0] flags_nxt;

  dbg_sema_bus_if #(.DW(DW)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (bus_sel),
    .wr_i       (bus_wr),
    .size_i     (bus_size),
    .wdata_i    (bus_wdata),
    .flags_i    (flags),
    .set_en_o   (set_en),
    .set_mask_o (set_mask),
    .rdata_o    (bus_rdata),
    .err_o      (bus_err)
  );

  dbg_sema_flags #(.DW(DW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en_i    (set_en),
    .set_mask_i  (set_mask),
    .clr_i       (dbg_clr),
    .flags_o     (flags),
    .flags_nxt_o (flags_nxt)
  );

  dbg_sema_dbg_port #(.DW(DW)) u_dbg (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_rst_n (dbg_rst_n),
    .rd_i      (dbg_rd),
    .flags_i   (flags),
    .clr_o     (dbg_clr),
    .rdata_o   (dbg_rdata),
    .rvalid_o  (dbg_rvalid)
  );

  dbg_sema_trig #(.DW(DW)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags_nxt_i (flags_nxt),
    .trig_o      (trig_out)
  );

  // R9
  trig_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out == (|flags));

  // R8
  dbg_rst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_rst_n && !set_en) |=> $stable(flags));

endmodule

// File: tb/dbg_sema_reg_tb_top.sv
`timescale 1ns/1ps
module dbg_sema_reg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_rst_n = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        dbg_rd = 1'b0;
  logic [31:0] dbg_rdata;
  logic        dbg_rvalid;
  logic        trig_out;

  always #4 clk = ~clk;

  dbg_sema_reg dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .dbg_rd(dbg_rd), .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid),
    .trig_out(trig_out)
  );

  typedef struct {
    int          due;
    int          ch;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        mon_it;
  logic [31:0] mon_act;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] mdl;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int ch, input logic [31:0] e, input string r);
    sb_q.push_back('{cyc + 1, ch, e, r});
  endtask

  task automatic judge(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: compares design outputs with queued expectations
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      mon_it = sb_q.pop_front();
      case (mon_it.ch)
        0: mon_act = bus_rdata;
        1: mon_act = dbg_rdata;
        2: mon_act = {31'd0, trig_out};
        3: mon_act = {31'd0, bus_err};
        default: mon_act = {31'd0, dbg_rvalid};
      endcase
      judge(mon_it.req, mon_act, mon_it.exp);
    end
  end

  // driver: one cycle of stimulus plus its expected results
  task automatic op(input bit sel, input bit wr, input logic [1:0] sz,
                    input logic [31:0] wd, input bit drd, input bit jrst,
                    input string tag);
    bit valid, dbg_eff, wr_eff;
    @(negedge clk);
    bus_sel   = sel;
    bus_wr    = wr;
    bus_size  = sz;
    bus_wdata = wd;
    dbg_rd    = drd;
    dbg_rst_n = !jrst;
    valid   = (sz == 2'b10);
    dbg_eff = drd && !jrst;
    wr_eff  = sel && wr && valid;
    push(3, {31'd0, sel && !valid}, {"R5 err ", tag});
    push(4, {31'd0, dbg_eff}, {"R6 rvalid ", tag});
    if (dbg_eff) push(1, mdl, {"R6 dbg data ", tag});
    if (sel && !wr && valid) push(0, mdl, {"R4 bus data ", tag});
    if (dbg_eff) mdl = wr_eff ? wd : 32'd0;
    else if (wr_eff) mdl = mdl | wd;
    push(2, {31'd0, |mdl}, {"R9 trig ", tag});
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 2'b10, 32'd0, 1'b0, 1'b0, "idle");
  endtask

  task automatic rd_word(input string tag);
    op(1'b1, 1'b0, 2'b10, 32'd0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    mdl = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    judge("R1 trig in reset", {31'd0, trig_out}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    judge("R1 err after reset", {31'd0, bus_err}, 32'd0);
    judge("R1 rvalid after reset", {31'd0, dbg_rvalid}, 32'd0);
    judge("R1 trig after reset", {31'd0, trig_out}, 32'd1);
    rd_word("R1 all ones");
    // R6: debug read returns all ones and clears
    op(1'b0, 1'b0, 2'b10, 32'd0, 1'b1, 1'b0, "R6 first");
    rd_word("R6 cleared");
    // R2: OR merging
    op(1'b1, 1'b1, 2'b10, 32'h0000_00A5, 1'b0, 1'b0, "R2 a");
    op(1'b1, 1'b1, 2'b10, 32'h8001_0000, 1'b0, 1'b0, "R2 b");
    rd_word("R2 merged");
    // R3: zeros never clear
    op(1'b1, 1'b1, 2'b10, 32'h0000_0000, 1'b0, 1'b0, "R3 zero");
    op(1'b1, 1'b1, 2'b10, 32'h0000_0001, 1'b0, 1'b0, "R3 partial");
    rd_word("R3 kept");
    // R5: narrow or reserved sizes
    op(1'b1, 1'b1, 2'b00, 32'h0000_FF00, 1'b0, 1'b0, "R5 byte wr");
    op(1'b1, 1'b1, 2'b01, 32'h0F00_0000, 1'b0, 1'b0, "R5 half wr");
    op(1'b1, 1'b1, 2'b11, 32'h0000_0800, 1'b0, 1'b0, "R5 rsvd wr");
    op(1'b1, 1'b0, 2'b00, 32'd0, 1'b0, 1'b0, "R5 byte rd");
    idle();
    rd_word("R5 unchanged");
    // R4: a read does not change the flags
    rd_word("R4 again");
    // R6 then R9: debug read clears, trigger drops
    op(1'b0, 1'b0, 2'b10, 32'd0, 1'b1, 1'b0, "R6 second");
    idle();
    rd_word("R9 empty");
    op(1'b0, 1'b0, 2'b10, 32'd0, 1'b1, 1'b0, "R6 empty read");
    // R7: debug read and bus write in the same cycle
    op(1'b1, 1'b1, 2'b10, 32'h1234_0000, 1'b0, 1'b0, "R7 pre");
    op(1'b1, 1'b1, 2'b10, 32'h0000_0C00, 1'b1, 1'b0, "R7 collide");
    rd_word("R7 survivor");
    // R8: debug reset keeps flags and ignores debug reads
    op(1'b0, 1'b0, 2'b10, 32'd0, 1'b1, 1'b1, "R8 ignored rd");
    op(1'b1, 1'b1, 2'b10, 32'h0000_0002, 1'b1, 1'b1, "R8 wr in jrst");
    idle();
    rd_word("R8 kept");
    op(1'b0, 1'b0, 2'b10, 32'd0, 1'b1, 1'b0, "R8 after");
    rd_word("R9 final");
    idle();
    repeat (4) @(negedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule